// File: doc/BRIEF.md
# Low-Power State Sequencer

This block decides when a processor core may run. It tracks four states: running, idle (waiting for an interrupt), dormant (deep power-down), and waking (counting down the restart delay). A level request on the power-down pin or a software force bit puts the core into the dormant state. An idle strobe parks the core until an unmasked interrupt is pending. Throughout the idle state, cycle stealing by the DMA engines stays permitted.

Leaving the dormant state is triggered by releasing the power-down pin or by a synchronous reset request. A down-counter then holds the core clock off for a fixed number of input-clock cycles before the core runs again. That delay is short when the oscillator was left running and long when the oscillator was stopped and must restart. On a pin-triggered exit, a context input selects whether the core resumes as it was or receives a one-cycle context-clear strobe. A reset-triggered exit always clears the context.

Top module: `pwr_seq`

## Requirements
- R1: After `rst_ni` is released the block is running: core_clk_en_o=1, osc_en_o=1, pd_ack_o=0, ctx_clr_o=0, dma_ok_o=1.
- R2: From the running or idle state, `pd_pin_i` or `sw_pd_i` high at a clock edge enters the dormant state at that edge: pd_ack_o=1, core_clk_en_o=0, dma_ok_o=0. A power-down request takes priority over a simultaneous idle strobe.
- R3: While dormant, osc_en_o is 0 if `osc_stop_cfg_i` was 1 at the entry edge, and 1 otherwise.
- R4: While dormant, a release of `pd_pin_i` (high at one edge, low at the next) starts a wake. With the oscillator kept running, core_clk_en_o rises 200 edges after the release edge.
- R5: With the oscillator stopped, core_clk_en_o rises 4096 edges after the release edge, and osc_en_o is 1 from the release edge on.
- R6: On a pin-triggered exit, ctx_clr_o pulses for exactly the first running cycle if `ctx_keep_i` was 0 at the release edge. It stays 0 if `ctx_keep_i` was 1.
- R7: An `idle_i` strobe while running gives core_clk_en_o=0 and dma_ok_o=1. The block stays idle until `irq_pend_i` is sampled high, then runs from the next edge with no context clear.
- R8: `ext_rst_i` high at an edge, in any state, enters the waking state with pd_ack_o=0, core_clk_en_o=0 and osc_en_o=1. The delay (200 edges, or 4096 edges if it struck a dormant state with the oscillator stopped) is frozen while `ext_rst_i` stays high. The exit always pulses ctx_clr_o.
- R9: While dormant and `pd_pin_i` is held high, the block stays dormant, and `irq_pend_i` has no effect.
- R10: While waking, `pd_pin_i`, `sw_pd_i` and `idle_i` are ignored: outputs stay core_clk_en_o=0, osc_en_o=1, pd_ack_o=0, dma_ok_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_rst_i | input | 1 | Synchronous reset request that ends any state |
| pd_pin_i | input | 1 | Power-down pin level, high requests dormancy |
| sw_pd_i | input | 1 | Software power-down force bit |
| idle_i | input | 1 | Idle-instruction strobe |
| irq_pend_i | input | 1 | Unmasked interrupt pending |
| osc_stop_cfg_i | input | 1 | Stop the oscillator during dormancy |
| ctx_keep_i | input | 1 | 1 keeps the context on pin exit, 0 clears it |
| core_clk_en_o | output | 1 | Core clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| pd_ack_o | output | 1 | Power-down acknowledge |
| ctx_clr_o | output | 1 | One-cycle context-clear strobe |
| dma_ok_o | output | 1 | DMA cycle steals allowed |

## Verification
Every state change is registered exactly once, so each stimulus sampled at an edge shows on the outputs one edge later. The two wake delays follow the same rule: core_clk_en_o is due 200 or 4096 edges after the release or reset edge, plus one edge for each extra cycle that ext_rst_i is held. The driver records each expectation with the exact cycle number at which it is due, including the cycle just before each wake finishes. The monitor compares outputs a quarter period after that edge, so both an early and a late wake are caught.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_IDLE = 2'd1,
    PS_DORM = 2'd2,
    PS_WAKE = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pwr_edge_det.sv
`timescale 1ns/1ps
module pwr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign fall_o = lvl_q & ~lvl_i;

  // R4
  fall_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !lvl_q);
endmodule

// File: rtl/pwr_wake_cnt.sv
`timescale 1ns/1ps
module pwr_wake_cnt #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));

  // R4 R5
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> (cnt_q != '0));

  // R5
  load_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (load_val_i != '0));
endmodule

// File: rtl/pwr_seq_fsm.sv
`timescale 1ns/1ps
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int CNT_W     = 13,
  parameter int WAKE_FAST = 200,
  parameter int WAKE_SLOW = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_rst_i,
  input  logic             pd_req_i,
  input  logic             pin_rel_i,
  input  logic             idle_i,
  input  logic             irq_i,
  input  logic             osc_stop_cfg_i,
  input  logic             ctx_keep_i,
  input  logic             cnt_last_i,
  output pwr_state_e       state_o,
  output logic             osc_off_o,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output logic             cnt_dec_o,
  output logic             ctx_clr_o
);
  localparam logic [CNT_W-1:0] FAST_V = CNT_W'(WAKE_FAST);
  localparam logic [CNT_W-1:0] SLOW_V = CNT_W'(WAKE_SLOW);

  pwr_state_e state_q, state_d;
  logic osc_off_q, osc_off_d;
  logic clr_pend_q, clr_pend_d;
  logic ctx_clr_q, ctx_clr_d;
  logic osc_cold;

  assign osc_cold = (state_q == PS_DORM) && osc_off_q;

  always_comb begin
    state_d    = state_q;
    osc_off_d  = osc_off_q;
    clr_pend_d = clr_pend_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = FAST_V;
    if (ext_rst_i) begin
      state_d    = PS_WAKE;
      clr_pend_d = 1'b1;
      if (state_q != PS_WAKE) begin
        cnt_load_o = 1'b1;
        cnt_val_o  = osc_cold ? SLOW_V : FAST_V;
      end
    end else begin
      unique case (state_q)
        PS_RUN, PS_IDLE: begin
          if (pd_req_i) begin
            state_d   = PS_DORM;
            osc_off_d = osc_stop_cfg_i;
          end else if (state_q == PS_RUN && idle_i) begin
            state_d = PS_IDLE;
          end else if (state_q == PS_IDLE && irq_i) begin
            state_d = PS_RUN;
          end
        end
        PS_DORM: begin
          if (pin_rel_i) begin
            state_d    = PS_WAKE;
            cnt_load_o = 1'b1;
            cnt_val_o  = osc_off_q ? SLOW_V : FAST_V;
            clr_pend_d = ~ctx_keep_i;
          end
        end
        PS_WAKE: begin
          if (cnt_last_i) state_d = PS_RUN;
        end
        default: state_d = PS_RUN;
      endcase
    end
  end

  assign cnt_dec_o = (state_q == PS_WAKE) && !ext_rst_i;
  assign ctx_clr_d = (state_q == PS_WAKE) && (state_d == PS_RUN) && clr_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= PS_RUN;
      osc_off_q  <= 1'b0;
      clr_pend_q <= 1'b0;
      ctx_clr_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      osc_off_q  <= osc_off_d;
      clr_pend_q <= clr_pend_d;
      ctx_clr_q  <= ctx_clr_d;
    end
  end

  assign state_o   = state_q;
  assign osc_off_o = osc_off_q;
  assign ctx_clr_o = ctx_clr_q;

  // R10
  wake_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_WAKE && !cnt_last_i) |=> (state_q == PS_WAKE));

  // R8
  rst_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_i |=> clr_pend_q);
endmodule

// File: rtl/pwr_seq.sv
`timescale 1ns/1ps
module pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int WAKE_FAST = 200,
  parameter int WAKE_SLOW = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_i,
  input  logic pd_pin_i,
  input  logic sw_pd_i,
  input  logic idle_i,
  input  logic irq_pend_i,
  input  logic osc_stop_cfg_i,
  input  logic ctx_keep_i,
  output logic core_clk_en_o,
  output logic osc_en_o,
  output logic pd_ack_o,
  output logic ctx_clr_o,
  output logic dma_ok_o
);
  localparam int CNT_W = $clog2(WAKE_SLOW + 1);

  pwr_state_e       state;
  logic             osc_off;
  logic             pin_rel;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_dec;
  logic             cnt_last;

  pwr_edge_det u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (pd_pin_i),
    .fall_o (pin_rel)
  );

  pwr_wake_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .dec_i      (cnt_dec),
    .last_o     (cnt_last)
  );

  pwr_seq_fsm #(
    .CNT_W     (CNT_W),
    .WAKE_FAST (WAKE_FAST),
    .WAKE_SLOW (WAKE_SLOW)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ext_rst_i      (ext_rst_i),
    .pd_req_i       (pd_pin_i | sw_pd_i),
    .pin_rel_i      (pin_rel),
    .idle_i         (idle_i),
    .irq_i          (irq_pend_i),
    .osc_stop_cfg_i (osc_stop_cfg_i),
    .ctx_keep_i     (ctx_keep_i),
    .cnt_last_i     (cnt_last),
    .state_o        (state),
    .osc_off_o      (osc_off),
    .cnt_load_o     (cnt_load),
    .cnt_val_o      (cnt_val),
    .cnt_dec_o      (cnt_dec),
    .ctx_clr_o      (ctx_clr_o)
  );

  assign core_clk_en_o = (state == PS_RUN);
  assign pd_ack_o      = (state == PS_DORM);
  assign osc_en_o      = !((state == PS_DORM) && osc_off);
  assign dma_ok_o      = (state == PS_RUN) || (state == PS_IDLE);

  // R2
  enter_dorm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_ok_o && (pd_pin_i || sw_pd_i) && !ext_rst_i) |=> pd_ack_o);

  // R8
  ext_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_i |=> (!pd_ack_o && !core_clk_en_o && osc_en_o));

  // R9
  dorm_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_ack_o && pd_pin_i && !ext_rst_i) |=> pd_ack_o);

  // R6
  ctx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_clr_o |-> (core_clk_en_o && $rose(core_clk_en_o)));

  // R7
  idle_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_ok_o && !core_clk_en_o && irq_pend_i && !pd_pin_i && !sw_pd_i && !ext_rst_i)
      |=> (core_clk_en_o && !ctx_clr_o));
endmodule

// File: tb/sim_pwr_seq.sv
`timescale 1ns/1ps
module sim_pwr_seq;
  localparam int CLK_PER = 10;
  localparam int FAST    = 200;
  localparam int SLOW    = 4096;
  localparam int WDOG    = 60000;

  // {core_clk_en, osc_en, pd_ack, ctx_clr, dma_ok}
  localparam logic [4:0] V_RUN  = 5'b11001;
  localparam logic [4:0] V_RUNC = 5'b11011;
  localparam logic [4:0] V_IDLE = 5'b01001;
  localparam logic [4:0] V_DON  = 5'b01100;
  localparam logic [4:0] V_DOFF = 5'b00100;
  localparam logic [4:0] V_WAKE = 5'b01000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_rst, pd_pin, sw_pd, idle, irq, osc_stop, ctx_keep;
  logic core_clk_en, osc_en, pd_ack, ctx_clr, dma_ok;
  int cyc = 0;
  int checks = 0;
  int errs = 0;

  typedef struct {
    int         cyc;
    logic [4:0] v;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_seq u0 (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .ext_rst_i      (ext_rst),
    .pd_pin_i       (pd_pin),
    .sw_pd_i        (sw_pd),
    .idle_i         (idle),
    .irq_pend_i     (irq),
    .osc_stop_cfg_i (osc_stop),
    .ctx_keep_i     (ctx_keep),
    .core_clk_en_o  (core_clk_en),
    .osc_en_o       (osc_en),
    .pd_ack_o       (pd_ack),
    .ctx_clr_o      (ctx_clr),
    .dma_ok_o       (dma_ok)
  );

  task automatic push(input int d, input logic [4:0] v, input string tag);
    exp_t e;
    e.cyc = cyc + d;
    e.v   = v;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  endtask

  // monitor: a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PER/4);
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc <= cyc) begin
        checks++;
        if (sb[i].cyc < cyc) begin
          errs++;
          $display("FAIL %s: expectation for cycle %0d missed, expected %b", sb[i].tag, sb[i].cyc, sb[i].v);
        end else if ({core_clk_en, osc_en, pd_ack, ctx_clr, dma_ok} !== sb[i].v) begin
          errs++;
          $display("FAIL %s: cycle %0d actual %b expected %b", sb[i].tag, cyc,
                   {core_clk_en, osc_en, pd_ack, ctx_clr, dma_ok}, sb[i].v);
        end
        sb.delete(i);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WDOG) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WDOG);
      finish_run();
    end
  end

  initial begin
    {ext_rst, pd_pin, sw_pd, idle, irq, osc_stop, ctx_keep} = '0;
    step(3);
    rst_ni = 1'b1;

    // R1 reset state
    push(1, V_RUN, "R1");
    push(2, V_RUN, "R1");
    step(1); drain();

    // R7 idle then interrupt
    idle = 1'b1;
    push(1, V_IDLE, "R7");
    step(1); idle = 1'b0;
    push(3, V_IDLE, "R7");
    step(3);
    irq = 1'b1;
    push(1, V_RUN, "R7");
    step(1); irq = 1'b0;
    drain();

    // R2 R3 pin entry, oscillator kept; R9 pin held with interrupt
    pd_pin = 1'b1;
    push(1, V_DON, "R2");
    step(1);
    irq = 1'b1;
    push(5, V_DON, "R9");
    step(5); irq = 1'b0;
    drain();
    // R4 R6 release with context kept
    ctx_keep = 1'b1;
    pd_pin   = 1'b0;
    push(1, V_WAKE, "R4");
    push(FAST, V_WAKE, "R4");
    push(FAST + 1, V_RUN, "R4");
    push(FAST + 2, V_RUN, "R6");
    step(6);
    // R10 requests during wake
    sw_pd = 1'b1; idle = 1'b1; pd_pin = 1'b1;
    push(1, V_WAKE, "R10");
    step(1);
    sw_pd = 1'b0; idle = 1'b0; pd_pin = 1'b0;
    push(1, V_WAKE, "R10");
    step(1);
    drain();

    // R2 R3 software entry from idle, oscillator stopped
    idle = 1'b1;
    push(1, V_IDLE, "R7");
    step(1); idle = 1'b0;
    sw_pd = 1'b1; osc_stop = 1'b1;
    push(1, V_DOFF, "R3");
    step(1); sw_pd = 1'b0; osc_stop = 1'b0;
    push(2, V_DOFF, "R9");
    step(2);
    pd_pin = 1'b1;
    push(1, V_DOFF, "R9");
    step(1); drain();
    // R5 R6 release with context cleared
    ctx_keep = 1'b0;
    pd_pin   = 1'b0;
    push(1, V_WAKE, "R5");
    push(SLOW, V_WAKE, "R5");
    push(SLOW + 1, V_RUNC, "R6");
    push(SLOW + 2, V_RUN, "R6");
    step(1); drain();

    // R2 power-down wins over idle strobe
    ctx_keep = 1'b1;
    pd_pin = 1'b1; idle = 1'b1;
    push(1, V_DON, "R2");
    step(1); idle = 1'b0;
    drain();

    // R8 reset pulse while dormant, oscillator running
    ext_rst = 1'b1;
    push(1, V_WAKE, "R8");
    push(FAST, V_WAKE, "R8");
    push(FAST + 1, V_RUNC, "R8");
    push(FAST + 2, V_RUN, "R8");
    step(1); ext_rst = 1'b0; pd_pin = 1'b0;
    drain();

    // R8 reset held three cycles while dormant, oscillator stopped
    pd_pin = 1'b1; osc_stop = 1'b1;
    push(1, V_DOFF, "R3");
    step(1); drain();
    ext_rst = 1'b1;
    push(1, V_WAKE, "R8");
    push(SLOW + 2, V_WAKE, "R8");
    push(SLOW + 3, V_RUNC, "R8");
    step(3); ext_rst = 1'b0; pd_pin = 1'b0; osc_stop = 1'b0;
    drain();

    // R8 reset from idle
    idle = 1'b1;
    push(1, V_IDLE, "R7");
    step(1); idle = 1'b0;
    ext_rst = 1'b1;
    push(1, V_WAKE, "R8");
    push(FAST, V_WAKE, "R8");
    push(FAST + 1, V_RUNC, "R8");
    step(1); ext_rst = 1'b0;
    drain();

    step(2);
    finish_run();
  end
endmodule